// File: doc/BRIEF.md
# Analog test bus interface controller

This block is the digital controller for the pair of analog test pins on a mixed-signal boundary-scan device. It holds a four-bit segment of the data register chain, with a capture/shift stage and an update stage. It decodes the update latches together with the class of the active instruction, and from that drives one-hot enables for the analog switches. Each test pin can be joined to one of two internal analog bus lines, driven to a high or low level, tied to a clamp source, or left isolated. The switches, the comparators and the TAP state machine sit outside the block. The TAP supplies capture, shift and update strobes plus a segment select, and two comparator inputs report how each test pin's voltage compares with the threshold.

The shift stage has three operations: hold, capture and shift. Capture takes priority over shift, and with the segment deselected the stage holds. The update latches load from the shift stage on the falling edge of the test clock while the update strobe and the select are both high. The update latches drive the switch decoder directly, with no multiplexer between them. For each pin the decoder picks one of six routes: off, bus line 1, bus line 2, high, low or clamp. The route is gated by the instruction class.

Top module: `atbic_ctrl`

## Requirements
- R1: While `trst_n` is low, every bit of `at1_sw` and `at2_sw` is 0 whatever the instruction class. The reset also clears the update latches, so under the external-drive class (01) both pins read isolated once reset is released.
- R2: The chain bits, in shift order, are TDI, CALIBRATE (segment bit 0), CONTROL (bit 1), DATA1 (bit 2), DATA2 (bit 3) and then `tdo`. Each rising `tck` edge with `seg_sel` and `shift_dr` high moves the chain by one bit. `tdo` always shows DATA2.
- R3: A rising `tck` edge with `seg_sel` and `capture_dr` high loads `cmp_at1` into DATA1 and `cmp_at2` into DATA2. The same edge loads the current update-latch values into CALIBRATE and CONTROL. Capture wins over shift.
- R4: The update latches load the shift stage on a falling `tck` edge with `seg_sel` and `update_dr` high, and they hold at every other time. Capture and shift leave `at1_sw` and `at2_sw` unchanged.
- R5: Under the probe class (`instr_class`=10), `at1_sw`=00001 (bus line 1) and `at2_sw`=00010 (bus line 2), whatever the latches hold.
- R6: Under the pass class (00, bypass or sample/preload) and under class 11, both pins are isolated (enables all 0).
- R7: Under the external-drive class (01), each pin decodes CALIBRATE, CONTROL and its own data bit (DATA1 for pin 1, DATA2 for pin 2). CONTROL=0 and CAL=0 gives off. CONTROL=0 and CAL=1 gives clamp (10000). CONTROL=1 and CAL=0 gives the pin's own bus line when its data bit is 1 and low (01000) when it is 0. CONTROL=1 and CAL=1 gives high (00100) when the data bit is 1 and low (01000) when it is 0.
- R8: At most one enable bit per pin is high at any time. The enable bit order is bit0 bus line 1, bit1 bus line 2, bit2 high, bit3 low, bit4 clamp.
- R9: While `seg_sel` is low, the capture, shift and update strobes have no effect on the segment or on the switch enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| seg_sel | input | 1 | This segment is in the selected data register path |
| capture_dr | input | 1 | TAP is in the capture state |
| shift_dr | input | 1 | TAP is in the shift state |
| update_dr | input | 1 | TAP is in the update state |
| instr_class | input | 2 | 00 pass, 01 external drive, 10 probe, 11 other |
| tdi | input | 1 | Serial data in |
| cmp_at1 | input | 1 | Comparator result for test pin 1 |
| cmp_at2 | input | 1 | Comparator result for test pin 2 |
| tdo | output | 1 | Serial data out (DATA2) |
| at1_sw | output | 5 | One-hot switch enables for test pin 1 |
| at2_sw | output | 5 | One-hot switch enables for test pin 2 |

## Verification
The switch enables are combinational from the instruction class and the update latches. They are therefore due 1 ns after an instruction change, or a few ns after the falling edge that ends an update. `tdo` reflects a capture or shift from the rising edge that performs it. The driver changes inputs 5 ns after a rising edge. It posts each expected value to the scoreboard queue only once the causing edge has passed, and the monitor compares it 1 ns later, clear of any clock edge.

// File: rtl/atbic_pkg.sv
package atbic_pkg;
    localparam int SEG_W   = 4;
    localparam int N_PINS  = 2;
    localparam int SW_W    = 5;
    localparam int BIT_CAL = 0;
    localparam int BIT_CTL = 1;
    localparam int BIT_D1  = 2;
    localparam int BIT_D2  = 3;
    localparam int SW_AB1   = 0;
    localparam int SW_AB2   = 1;
    localparam int SW_HI    = 2;
    localparam int SW_LO    = 3;
    localparam int SW_CLAMP = 4;

    typedef enum logic [1:0] {
        IC_PASS  = 2'b00,
        IC_DRIVE = 2'b01,
        IC_PROBE = 2'b10,
        IC_OTHER = 2'b11
    } iclass_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_CAPTURE,
        OP_SHIFT
    } chain_op_e;

    typedef enum logic [2:0] {
        RT_OFF,
        RT_AB1,
        RT_AB2,
        RT_HI,
        RT_LO,
        RT_CLAMP
    } route_e;
endpackage

// File: rtl/atbic_chain.sv
module atbic_chain
    import atbic_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             seg_sel,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             tdi,
    input  logic             cmp_at1,
    input  logic             cmp_at2,
    input  logic [SEG_W-1:0] hold_q,
    output logic [SEG_W-1:0] seg_q,
    output logic             tdo
);
    chain_op_e        op;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
        op = OP_HOLD;
        if (seg_sel) begin
            if (capture_dr)    op = OP_CAPTURE;
            else if (shift_dr) op = OP_SHIFT;
        end
    end

    always_comb begin
        seg_d = seg_q;
        unique case (op)
            OP_HOLD: seg_d = seg_q;
            OP_CAPTURE: begin
                seg_d[BIT_CAL] = hold_q[BIT_CAL];
                seg_d[BIT_CTL] = hold_q[BIT_CTL];
                seg_d[BIT_D1]  = cmp_at1;
                seg_d[BIT_D2]  = cmp_at2;
            end
            OP_SHIFT: seg_d = {seg_q[SEG_W-2:0], tdi};
            default: seg_d = seg_q;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) seg_q <= '0;
        else         seg_q <= seg_d;
    end

    assign tdo = seg_q[SEG_W-1];

    p_shift_in_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (seg_sel && shift_dr && !capture_dr) |=> (seg_q[BIT_CAL] == $past(tdi)
            && seg_q[BIT_D2] == $past(seg_q[BIT_D1])));

    p_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
        (seg_sel && capture_dr) |=> (seg_q[BIT_D1] == $past(cmp_at1)
            && seg_q[BIT_D2] == $past(cmp_at2)));

    // R9: deselected segment keeps its contents
    p_idle_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !seg_sel |=> $stable(seg_q));
endmodule

// File: rtl/atbic_update.sv
module atbic_update
    import atbic_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             seg_sel,
    input  logic             update_dr,
    input  logic [SEG_W-1:0] seg_q,
    output logic [SEG_W-1:0] upd_q
);
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                   upd_q <= '0;
        else if (seg_sel && update_dr) upd_q <= seg_q;
    end

    // R4 and R9: latches move only on a selected update
    p_hold_r4: assert property (@(negedge tck) disable iff (!trst_n)
        !(seg_sel && update_dr) |=> $stable(upd_q));
endmodule

// File: rtl/atbic_route.sv
module atbic_route
    import atbic_pkg::*;
#(
    parameter int PIN = 0
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic [1:0]      instr_class,
    input  logic            cal,
    input  logic            ctl,
    input  logic            dat,
    output logic [SW_W-1:0] sw
);
    localparam route_e BUS_RT  = (PIN == 0) ? RT_AB1 : RT_AB2;
    localparam int     BUS_BIT = (PIN == 0) ? SW_AB1 : SW_AB2;

    iclass_e ic;
    route_e  rt;

    assign ic = iclass_e'(instr_class);

    always_comb begin
        rt = RT_OFF;
        unique case (ic)
            IC_PROBE: rt = BUS_RT;
            IC_DRIVE: begin
                if (!ctl)     rt = cal ? RT_CLAMP : RT_OFF;
                else if (cal) rt = dat ? RT_HI : RT_LO;
                else          rt = dat ? BUS_RT : RT_LO;
            end
            IC_PASS:  rt = RT_OFF;
            IC_OTHER: rt = RT_OFF;
            default:  rt = RT_OFF;
        endcase
        if (!trst_n) rt = RT_OFF;
    end

    always_comb begin
        sw = '0;
        unique case (rt)
            RT_OFF:   sw = '0;
            RT_AB1:   sw[SW_AB1]   = 1'b1;
            RT_AB2:   sw[SW_AB2]   = 1'b1;
            RT_HI:    sw[SW_HI]    = 1'b1;
            RT_LO:    sw[SW_LO]    = 1'b1;
            RT_CLAMP: sw[SW_CLAMP] = 1'b1;
            default:  sw = '0;
        endcase
    end

    p_onehot_r8: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(sw));

    p_probe_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_class == 2'b10) |-> (sw[BUS_BIT] && $countones(sw) == 1));

    p_isolate_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (instr_class == 2'b00 || instr_class == 2'b11) |-> (sw == '0));
endmodule

// File: rtl/atbic_ctrl.sv
module atbic_ctrl
    import atbic_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            seg_sel,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic [1:0]      instr_class,
    input  logic            tdi,
    input  logic            cmp_at1,
    input  logic            cmp_at2,
    output logic            tdo,
    output logic [SW_W-1:0] at1_sw,
    output logic [SW_W-1:0] at2_sw
);
    logic [SEG_W-1:0]             seg_q;
    logic [SEG_W-1:0]             upd_q;
    logic [N_PINS-1:0][SW_W-1:0] sw_all;

    atbic_chain u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .seg_sel    (seg_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cmp_at1    (cmp_at1),
        .cmp_at2    (cmp_at2),
        .hold_q     (upd_q),
        .seg_q      (seg_q),
        .tdo        (tdo)
    );

    atbic_update u_update (
        .tck       (tck),
        .trst_n    (trst_n),
        .seg_sel   (seg_sel),
        .update_dr (update_dr),
        .seg_q     (seg_q),
        .upd_q     (upd_q)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        atbic_route #(.PIN(g)) u_route (
            .tck         (tck),
            .trst_n      (trst_n),
            .instr_class (instr_class),
            .cal         (upd_q[BIT_CAL]),
            .ctl         (upd_q[BIT_CTL]),
            .dat         (upd_q[BIT_D1+g]),
            .sw          (sw_all[g])
        );
    end

    assign at1_sw = sw_all[0];
    assign at2_sw = sw_all[1];
endmodule

// File: tb/test_atbic_ctrl.sv
`timescale 1ns/1ps
module test_atbic_ctrl;
    typedef struct {
        string      tag;
        bit         is_tdo;
        logic [4:0] e1;
        logic [4:0] e2;
        logic       et;
    } item_t;

    logic       tck = 0, trst_n = 0, seg_sel = 0;
    logic       capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic [1:0] instr_class = 2'b10;
    logic       tdi = 0, cmp_at1 = 0, cmp_at2 = 0;
    logic       tdo;
    logic [4:0] at1_sw, at2_sw;

    int    checks = 0, fails = 0;
    bit    done = 0;
    item_t sbq[$];
    event  ev_chk;

    localparam logic [4:0] OFF = 5'b00000, AB1 = 5'b00001, AB2 = 5'b00010,
                           HI = 5'b00100, LO = 5'b01000, CLP = 5'b10000;

    atbic_ctrl i_atbic_ctrl (.*);

    always #10 tck = ~tck;

    task automatic post_sw(string tag, logic [4:0] e1, logic [4:0] e2);
        sbq.push_back('{tag, 1'b0, e1, e2, 1'b0});
        #1; ->ev_chk; #1;
    endtask

    task automatic post_tdo(string tag, logic et);
        sbq.push_back('{tag, 1'b1, OFF, OFF, et});
        #1; ->ev_chk; #1;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(ev_chk);
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                if (it.is_tdo) begin
                    checks++;
                    if (tdo !== it.et) begin
                        fails++;
                        $display("FAIL %s: tdo=%b expected %b", it.tag, tdo, it.et);
                    end
                end else begin
                    checks++;
                    if (at1_sw !== it.e1 || at2_sw !== it.e2) begin
                        fails++;
                        $display("FAIL %s: at1_sw=%b at2_sw=%b expected %b %b",
                                 it.tag, at1_sw, at2_sw, it.e1, it.e2);
                    end
                    checks++;
                    if ($countones(at1_sw) > 1 || $countones(at2_sw) > 1) begin
                        fails++;
                        $display("FAIL R8 (%s): at1_sw=%b at2_sw=%b expected at most one bit each",
                                 it.tag, at1_sw, at2_sw);
                    end
                end
            end
        end
    end

    task automatic shift1(logic b);
        tdi = b; shift_dr = 1;
        @(posedge tck); #5;
        shift_dr = 0;
    endtask

    task automatic shift_seg(logic cal, logic ctl, logic d1, logic d2);
        logic [3:0] seq;
        seq = {cal, ctl, d1, d2};
        for (int i = 0; i < 4; i++) shift1(seq[i]);
    endtask

    task automatic upd();
        update_dr = 1;
        @(negedge tck); #2;
        update_dr = 0;
        @(posedge tck); #5;
    endtask

    task automatic load(logic cal, logic ctl, logic d1, logic d2);
        shift_seg(cal, ctl, d1, d2);
        upd();
    endtask

    task automatic capture(logic c1, logic c2);
        cmp_at1 = c1; cmp_at2 = c2; capture_dr = 1;
        @(posedge tck); #5;
        capture_dr = 0;
    endtask

    initial begin : driver
        #5;
        post_sw("R1 reset under probe", OFF, OFF);
        @(posedge tck); #5;
        trst_n = 1; seg_sel = 1;
        post_sw("R5 probe after reset", AB1, AB2);
        instr_class = 2'b00; post_sw("R6 pass class", OFF, OFF);
        instr_class = 2'b11; post_sw("R6 other class", OFF, OFF);
        instr_class = 2'b01; post_sw("R1 latches cleared", OFF, OFF);

        shift_seg(0, 1, 1, 1);
        post_sw("R4 shift leaves switches", OFF, OFF);
        upd();
        post_sw("R7 bus on both", AB1, AB2);
        load(0, 1, 0, 0); post_sw("R7 both low", LO, LO);
        load(1, 1, 1, 0); post_sw("R7 high and low", HI, LO);
        load(1, 0, 0, 0); post_sw("R7 clamp both", CLP, CLP);
        load(0, 1, 1, 0); post_sw("R7 bus and low", AB1, LO);
        load(0, 1, 0, 1); post_sw("R7 low and bus", LO, AB2);
        load(0, 0, 1, 1); post_sw("R7 off with data set", OFF, OFF);

        load(1, 0, 0, 0);
        instr_class = 2'b10; post_sw("R5 probe ignores latches", AB1, AB2);
        instr_class = 2'b00; post_sw("R6 pass ignores latches", OFF, OFF);
        instr_class = 2'b01;

        capture(1, 0);
        post_tdo("R3 DATA2 captures cmp_at2", 1'b0);
        post_sw("R4 capture leaves switches", CLP, CLP);
        shift1(0); post_tdo("R3 DATA1 captures cmp_at1", 1'b1);
        shift1(0); post_tdo("R3 CONTROL from latch", 1'b0);
        shift1(0); post_tdo("R3 CALIBRATE from latch", 1'b1);
        capture(0, 1);
        post_tdo("R3 second capture DATA2", 1'b1);
        shift1(0); post_tdo("R3 second capture DATA1", 1'b0);

        shift_seg(0, 0, 0, 1); post_tdo("R2 first bit at tdo", 1'b1);
        shift1(0); post_tdo("R2 DATA1 follows", 1'b0);
        shift_seg(1, 0, 0, 0); post_tdo("R2 DATA2 zero", 1'b0);
        shift1(0); shift1(0); shift1(0);
        post_tdo("R2 CALIBRATE reaches tdo", 1'b1);

        load(0, 1, 1, 1);
        post_sw("R9 setup", AB1, AB2);
        seg_sel = 0;
        shift_seg(1, 1, 0, 0);
        upd();
        post_sw("R9 deselected strobes ignored", AB1, AB2);
        capture(0, 0);
        post_tdo("R9 deselected chain unchanged", 1'b1);
        seg_sel = 1;

        trst_n = 0;
        post_sw("R1 reset mid-run", OFF, OFF);
        @(posedge tck); #5;
        trst_n = 1;
        post_sw("R1 isolated after reset", OFF, OFF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule